// File: doc/BRIEF.md
# Stacked DRAM Layer Enable Controller

This block sits beside one SRAM cache bank that has a DRAM layer stacked on top of it. Over a long, fixed evaluation epoch it counts the lookups that reach the bank and the misses that the bank reports. At the last cycle of each epoch it compares both counts against two programmable thresholds. It then decides whether the DRAM layer should be powered for the next epoch.

Both counts must point the same way before the state changes. High usage together with a high miss count turns the layer on. Low usage together with a low miss count turns it off. Any other combination leaves the state as it is. Each real change raises a stall request to all cores for a fixed number of cycles while the layer settles.

The block also drives two outputs for the cache. One is a way mask. The two low-latency SRAM ways stay in the mask at all times, and the DRAM ways join it only while the layer is on. The other is a mode flag that tells the adaptive SRAM array whether to hold tags for the DRAM ways or to hold data.

Top module: `dram_layer_ctrl`

## Requirements
- R1: After reset, `dram_en` is 0, `stall_req` is 0, `tag_mode` is 0 and `way_mask` has only bits 0 to SRAM_WAYS-1 set.
- R2: `dram_en` can change only in the first cycle of an epoch. Within an epoch it holds its value from that first cycle onward. An epoch is EPOCH_CYCLES cycles long, and the first epoch starts in the first cycle after reset is released.
- R3: At the end of an epoch, if the access count is strictly greater than `use_thr` and the miss count is strictly greater than `miss_thr`, the layer becomes enabled. Both counts include every cycle of the epoch, the last cycle among them.
- R4: At the end of an epoch, if the access count is strictly below `use_thr` and the miss count is strictly below `miss_thr`, the layer becomes disabled.
- R5: For every other outcome, the enable state is kept and no stall is raised. This covers one count high and the other low, and any count equal to its threshold.
- R6: When a decision changes the enable state, `stall_req` goes high in the cycle after the decision. That is the same cycle in which `dram_en` takes its new value. It stays high for exactly STALL_CYCLES cycles.
- R7: The access and miss counters saturate at 2^CNT_W-1 and do not wrap.
- R8: Both counters restart from zero at every epoch boundary, so counts never carry from one epoch into the next.
- R9: While the layer is enabled, `way_mask` is all ones. While it is disabled, `way_mask` has only bits 0 to SRAM_WAYS-1 set, so the SRAM ways are never dropped.
- R10: `tag_mode` is 1 while the layer is enabled, meaning the adaptive array holds tags for the DRAM ways. It is 0 while the layer is disabled, meaning the array holds data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| access_pulse | input | 1 | One lookup reached the bank this cycle |
| miss_pulse | input | 1 | One lookup missed in the bank this cycle |
| use_thr | input | CNT_W | Usage threshold |
| miss_thr | input | CNT_W | Miss threshold |
| dram_en | output | 1 | The stacked DRAM layer is powered |
| stall_req | output | 1 | Stall request to all cores |
| tag_mode | output | 1 | The adaptive array holds DRAM tags (1) or data (0) |
| way_mask | output | WAYS | Ways valid for lookup and allocation |

## Verification
The bench puts an event in the very last cycle of an epoch. A design that dropped that event would see counts exactly equal to the thresholds and keep the layer off. It sets the counts equal to the thresholds while the layer is on. A design that compared with "or equal" would switch the layer off wrongly. It runs mixed epochs in both directions, where a design that acted on a single condition would toggle and stall with no need. It fills the counters past their width, where a wrapping counter would fall below the thresholds. It then runs an idle epoch with thresholds of 1, where a counter that did not clear would keep the layer on. It counts stall cycles in every epoch, which exposes a stall window that is one cycle too long or too short, or a stall raised without a change.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
    typedef enum logic [1:0] {
        DEC_KEEP = 2'd0,
        DEC_ON   = 2'd1,
        DEC_OFF  = 2'd2
    } dlc_dec_e;

    localparam int unsigned DLC_NUM_CNT = 2;
    localparam int unsigned DLC_IDX_USE = 0;
    localparam int unsigned DLC_IDX_MISS = 1;
endpackage

// File: rtl/dlc_sat_cnt.sv
module dlc_sat_cnt #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] total
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        total = (st_q.cnt == MAXV) ? MAXV : st_q.cnt + {{(W-1){1'b0}}, inc};
        if (clr) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == MAXV && !clr) |=> (st_q.cnt == MAXV));

    // R8
    epoch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));
endmodule

// File: rtl/dlc_epoch_timer.sv
module dlc_epoch_timer #(
    parameter int unsigned EPOCH_CYCLES = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic epoch_end
);
    localparam int unsigned TW = (EPOCH_CYCLES > 2) ? $clog2(EPOCH_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(EPOCH_CYCLES - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        epoch_end = (st_q.cnt == LAST);
        st_d.cnt  = epoch_end ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    epoch_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_end |=> (st_q.cnt == '0));
endmodule

// File: rtl/dram_layer_ctrl.sv
module dram_layer_ctrl #(
    parameter int unsigned EPOCH_CYCLES = 10_000_000,
    parameter int unsigned STALL_CYCLES = 100_000,
    parameter int unsigned CNT_W        = 24,
    parameter int unsigned WAYS         = 32,
    parameter int unsigned SRAM_WAYS    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             access_pulse,
    input  logic             miss_pulse,
    input  logic [CNT_W-1:0] use_thr,
    input  logic [CNT_W-1:0] miss_thr,
    output logic             dram_en,
    output logic             stall_req,
    output logic             tag_mode,
    output logic [WAYS-1:0]  way_mask
);
    import dlc_pkg::*;

    localparam int unsigned SW = $clog2(STALL_CYCLES + 1);
    localparam logic [SW-1:0] STALL_LAST = SW'(STALL_CYCLES - 1);
    localparam logic [WAYS-1:0] SRAM_MASK =
        {{(WAYS-SRAM_WAYS){1'b0}}, {SRAM_WAYS{1'b1}}};

    typedef struct packed {
        logic          en;
        logic          stall;
        logic [SW-1:0] left;
    } st_t;

    st_t st_d, st_q;

    logic                         epoch_end;
    logic [DLC_NUM_CNT-1:0]       ev_pulse;
    logic [DLC_NUM_CNT-1:0][CNT_W-1:0] ev_total;
    logic [DLC_NUM_CNT-1:0][CNT_W-1:0] ev_thr;
    logic [DLC_NUM_CNT-1:0]       ev_hi, ev_lo;
    dlc_dec_e                     dec;

    assign ev_pulse[DLC_IDX_USE]  = access_pulse;
    assign ev_pulse[DLC_IDX_MISS] = miss_pulse;
    assign ev_thr[DLC_IDX_USE]    = use_thr;
    assign ev_thr[DLC_IDX_MISS]   = miss_thr;

    dlc_epoch_timer #(.EPOCH_CYCLES(EPOCH_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .epoch_end (epoch_end)
    );

    for (genvar g = 0; g < DLC_NUM_CNT; g++) begin : g_cnt
        dlc_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ev_pulse[g]),
            .clr   (epoch_end),
            .total (ev_total[g])
        );
        assign ev_hi[g] = ev_total[g] > ev_thr[g];
        assign ev_lo[g] = ev_total[g] < ev_thr[g];
    end

    always_comb begin
        st_d = st_q;
        if (&ev_hi) begin
            dec = DEC_ON;
        end else if (&ev_lo) begin
            dec = DEC_OFF;
        end else begin
            dec = DEC_KEEP;
        end

        if (st_q.stall) begin
            if (st_q.left == '0) begin
                st_d.stall = 1'b0;
            end else begin
                st_d.left = st_q.left - 1'b1;
            end
        end

        if (epoch_end) begin
            if ((dec == DEC_ON && !st_q.en) || (dec == DEC_OFF && st_q.en)) begin
                st_d.en    = !st_q.en;
                st_d.stall = 1'b1;
                st_d.left  = STALL_LAST;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dram_en   = st_q.en;
    assign stall_req = st_q.stall;
    assign tag_mode  = st_q.en;
    assign way_mask  = st_q.en ? {WAYS{1'b1}} : SRAM_MASK;

    // R6
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_req) |-> (dram_en != $past(dram_en)));

    // R6
    flip_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_en != $past(dram_en)) |-> (stall_req && st_q.left == STALL_LAST));

    // R6
    stall_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_req && st_q.left == '0 && !epoch_end) |=> !stall_req);

    // R2
    flip_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_en != $past(dram_en)) |-> $past(epoch_end));

    // R5
    keep_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (epoch_end && dec == DEC_KEEP) |=> $stable(dram_en));

    // R9
    sram_ways_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&way_mask[SRAM_WAYS-1:0]));
endmodule

// File: tb/dram_layer_ctrl_test.sv
module dram_layer_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int EPOCH = 40;
    localparam int STALL = 6;
    localparam int CW = 5;
    localparam int NW = 8;
    localparam int SW = 2;
    localparam int SRAM_ONLY = 3;
    localparam int ALL_WAYS = 255;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc = 1'b0;
    logic miss = 1'b0;
    logic [CW-1:0] use_thr = '0;
    logic [CW-1:0] miss_thr = '0;
    logic dram_en, stall_req, tag_mode;
    logic [NW-1:0] way_mask;

    int total_checks = 0;
    int bad_checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_layer_ctrl #(
        .EPOCH_CYCLES (EPOCH),
        .STALL_CYCLES (STALL),
        .CNT_W        (CW),
        .WAYS         (NW),
        .SRAM_WAYS    (SW)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .access_pulse (acc),
        .miss_pulse   (miss),
        .use_thr      (use_thr),
        .miss_thr     (miss_thr),
        .dram_en      (dram_en),
        .stall_req    (stall_req),
        .tag_mode     (tag_mode),
        .way_mask     (way_mask)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total_checks++;
        if (act != exp) begin
            bad_checks++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drives one whole epoch from a negedge at its first cycle; returns stall and enable observations.
    task automatic run_epoch(input int n_acc, input int n_miss, input bit tail,
                             output int stall_cnt, output int stall_first, output int en_moves);
        logic first_en;
        first_en = 1'b0;
        stall_cnt = 0;
        stall_first = 0;
        en_moves = 0;
        for (int i = 0; i < EPOCH; i++) begin
            if (stall_req) stall_cnt++;
            if (i == 0) begin
                first_en = dram_en;
                stall_first = int'(stall_req);
            end else if (dram_en !== first_en) begin
                en_moves++;
            end
            acc  = tail ? (i >= EPOCH - n_acc)  : (i < n_acc);
            miss = tail ? (i >= EPOCH - n_miss) : (i < n_miss);
            @(negedge clk);
        end
        acc = 1'b0;
        miss = 1'b0;
    endtask

    task automatic check_end(input string req, input int exp_en, input int exp_stall);
        check(req, "dram_en", int'(dram_en), exp_en);
        check(req, "stall_req", int'(stall_req), exp_stall);
        check("R9", "way_mask", int'(way_mask), exp_en ? ALL_WAYS : SRAM_ONLY);
        check("R10", "tag_mode", int'(tag_mode), exp_en);
    endtask

    task automatic epoch_case(input string req, input int ua, input int mt, input int n_acc,
                              input int n_miss, input bit tail, input int exp_prev_stall,
                              input int exp_en, input int exp_stall);
        int sc, sf, mv;
        use_thr  = CW'(ua);
        miss_thr = CW'(mt);
        run_epoch(n_acc, n_miss, tail, sc, sf, mv);
        check("R6", {req, " stall cycles in epoch"}, sc, exp_prev_stall);
        check("R6", {req, " stall at first cycle"}, sf, exp_prev_stall > 0 ? 1 : 0);
        check("R2", {req, " enable moves inside epoch"}, mv, 0);
        check_end(req, exp_en, exp_stall);
    endtask

    task automatic t_reset;
        check("R1", "dram_en", int'(dram_en), 0);
        check("R1", "stall_req", int'(stall_req), 0);
        check("R1", "tag_mode", int'(tag_mode), 0);
        check("R1", "way_mask", int'(way_mask), SRAM_ONLY);
    endtask

    task automatic t_turn_on;      epoch_case("R3 both high",         10, 5, 20, 8, 1'b0, 0, 1, 1); endtask
    task automatic t_idle_off;     epoch_case("R4 both low",          10, 5, 0, 0, 1'b0, STALL, 0, 1); endtask
    task automatic t_mixed_use;    epoch_case("R5 use high miss low", 10, 5, 20, 2, 1'b0, STALL, 0, 0); endtask
    task automatic t_tail_on;      epoch_case("R3 last cycle event",  10, 5, 11, 6, 1'b1, 0, 1, 1); endtask
    task automatic t_mixed_miss;   epoch_case("R5 use low miss high", 10, 5, 2, 8, 1'b0, STALL, 1, 0); endtask
    task automatic t_equal_keep;   epoch_case("R5 equal thresholds",  10, 5, 10, 5, 1'b0, 0, 1, 0); endtask
    task automatic t_off_again;    epoch_case("R4 idle off",          10, 5, 0, 0, 1'b0, 0, 0, 1); endtask
    task automatic t_saturate;     epoch_case("R7 saturation",        30, 30, 40, 40, 1'b0, STALL, 1, 1); endtask
    task automatic t_clear;        epoch_case("R8 counters cleared",  1, 1, 0, 0, 1'b0, STALL, 0, 1); endtask
    task automatic t_settle;       epoch_case("R6 final settle",      1, 1, 0, 0, 1'b0, STALL, 0, 0); endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total_checks++;
            bad_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_turn_on();
        t_idle_off();
        t_mixed_use();
        t_tail_on();
        t_mixed_miss();
        t_equal_keep();
        t_off_again();
        t_saturate();
        t_clear();
        t_settle();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end
endmodule